// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences a single DMA channel through two nested loops. The inner loop moves one burst of words. The outer loop counts bursts until a whole transfer is complete. The sequencer raises a word request toward the bus side and waits for a per-word acknowledge. It emits per-word, per-burst and transfer-start strobes that an address generator uses to step its pointers. It also gives the channel arbiter a release strobe each time the channel gives up the bus.

Sizes are always counted in 16-bit units. In 32-bit mode each moved word consumes two units, so an odd unit count rounds up to a whole 32-bit word. By default one trigger buys one burst. In single-trigger mode one trigger drives every burst of the transfer. A continuous mode keeps the channel enabled once the transfer has finished. The interrupt pulse can be placed at the start or at the end of the transfer.

Top module: `dma_seq_top`

## Requirements
- R1: After reset, `chanActive`, `wordReq`, `busRelease`, `chanIrq` and `xferStart` are all low.
- R2: With `wide32`=0, each burst consists of `burstSize`+1 acknowledged words. `wordDone` pulses for every word that is acknowledged, and `burstDone` pulses together with the last word's `wordDone`.
- R3: With `wide32`=1, each burst consists of ceil((`burstSize`+1)/2) words, and `wordWide` is high while words are requested.
- R4: A transfer consists of `xferSize`+1 bursts. `xferStart` pulses exactly once per transfer, in the cycle its first burst begins.
- R5: With `oneShot`=0, each trigger yields one burst. `busRelease` pulses at the end of every burst, and `wordReq` drops after it even if a trigger is pending.
- R6: With `oneShot`=1, one trigger runs all bursts of the transfer back to back. `busRelease` pulses only with the final burst.
- R7: With `contMode`=0, `chanActive` falls after the final burst. Triggers seen while `chanActive` is low start nothing. A `runSet` pulse sets `chanActive`.
- R8: With `contMode`=1, `chanActive` stays high after the transfer completes.
- R9: With `intAtEnd`=0, `chanIrq` pulses together with `xferStart`. With `intAtEnd`=1, it pulses together with the final `burstDone`. Either way it pulses once per transfer.
- R10: Triggers that arrive while a burst is running are held as one pending request. Any number of them produces exactly one further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runSet | input | 1 | Pulse that enables the channel |
| trigIn | input | 1 | Channel trigger |
| oneShot | input | 1 | 1: one trigger runs the whole transfer |
| contMode | input | 1 | 1: channel stays enabled after a transfer |
| intAtEnd | input | 1 | 0: interrupt at transfer start, 1: at transfer end |
| wide32 | input | 1 | 1: 32-bit words (two units each) |
| burstSize | input | BURST_W | Units per burst minus one |
| xferSize | input | XFER_W | Bursts per transfer minus one |
| wordAck | input | 1 | Bus accepted the requested word |
| wordReq | output | 1 | Word transfer request |
| wordWide | output | 1 | Requested word is 32 bits |
| wordDone | output | 1 | A word completed |
| burstDone | output | 1 | Last word of a burst completed |
| xferStart | output | 1 | First burst of a transfer begins |
| chanIrq | output | 1 | Channel interrupt pulse |
| busRelease | output | 1 | Channel yields the bus to the arbiter |
| chanActive | output | 1 | Channel is enabled |

## Verification
A wrong unit counter shows up at the ports within the burst it corrupts: `burstDone` arrives one word early or late relative to the count of `wordDone` pulses. A wrong burst counter shows up by the end of the transfer, as a wrong total number of bursts, a misplaced end interrupt, or `chanActive` falling at the wrong time. A lost or duplicated pending flag appears one burst later, as a missing burst or an extra one after the bus release. A stuck first-burst flag appears at the next transfer, as a missing or repeated `xferStart`.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  // strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic loadBurst;  // reload unit counter
    logic loadXfer;   // reload burst counter
    logic wordMove;   // one word acknowledged
    logic burstEnd;   // current burst finished
  } seqCmd_t;
endpackage

// File: rtl/dma_seq_count.sv
module dma_seq_count
  import dma_seq_pkg::*;
#(
  parameter int BURST_W = 5,
  parameter int XFER_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmd_t            cmd,
  input  logic               wide32,
  input  logic [BURST_W-1:0] burstSize,
  input  logic [XFER_W-1:0]  xferSize,
  output logic               lastWord,
  output logic               lastBurst
);
  localparam int UNIT_W = BURST_W + 1;

  logic [UNIT_W-1:0] unitsLeft;
  logic [UNIT_W-1:0] unitStep;
  logic [XFER_W-1:0] burstsLeft;

  assign unitStep  = wide32 ? UNIT_W'(2) : UNIT_W'(1);
  assign lastWord  = (unitsLeft <= unitStep);
  assign lastBurst = (burstsLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitsLeft <= '0;
    end else if (cmd.loadBurst) begin
      unitsLeft <= {1'b0, burstSize} + UNIT_W'(1);
    end else if (cmd.wordMove) begin
      unitsLeft <= unitsLeft - unitStep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstsLeft <= '0;
    end else if (cmd.loadXfer) begin
      burstsLeft <= xferSize;
    end else if (cmd.burstEnd && !lastBurst) begin
      burstsLeft <= burstsLeft - XFER_W'(1);
    end
  end

  // a word is never moved with an exhausted unit counter (R2)
  p_units_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wordMove |-> (unitsLeft != '0));

  // a fresh transfer with size zero must be flagged as its last burst (R4)
  p_xfer_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadXfer |=> (lastBurst == ($past(xferSize) == '0)));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runSet,
  input  logic    trigIn,
  input  logic    oneShot,
  input  logic    contMode,
  input  logic    intAtEnd,
  input  logic    wordAck,
  input  logic    lastWord,
  input  logic    lastBurst,
  output seqCmd_t cmd,
  output logic    wordReq,
  output logic    wordDone,
  output logic    burstDone,
  output logic    xferStart,
  output logic    chanIrq,
  output logic    busRelease,
  output logic    chanActive
);
  typedef enum logic {ST_WAIT, ST_MOVE} seqState_t;

  seqState_t state;
  logic enabled, trigPend, firstBurst;
  logic xferEnd, startBurst, chainBurst, enNext;

  assign wordReq    = (state == ST_MOVE);
  assign wordDone   = wordReq && wordAck;
  assign burstDone  = wordDone && lastWord;
  assign xferEnd    = burstDone && lastBurst;
  assign startBurst = (state == ST_WAIT) && enabled && trigPend;
  assign xferStart  = startBurst && firstBurst;
  assign chainBurst = burstDone && oneShot && !lastBurst;
  assign busRelease = burstDone && !chainBurst;
  assign chanIrq    = intAtEnd ? xferEnd : xferStart;
  assign chanActive = enabled;
  assign enNext     = runSet || (enabled && !(xferEnd && !contMode));

  always_comb begin
    cmd.loadBurst = startBurst || chainBurst;
    cmd.loadXfer  = xferStart;
    cmd.wordMove  = wordDone;
    cmd.burstEnd  = burstDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_WAIT;
      enabled    <= 1'b0;
      trigPend   <= 1'b0;
      firstBurst <= 1'b1;
    end else begin
      enabled  <= enNext;
      trigPend <= enNext && (trigIn || (trigPend && !startBurst));
      if (startBurst)      state <= ST_MOVE;
      else if (busRelease) state <= ST_WAIT;
      if (xferEnd)        firstBurst <= 1'b1;
      else if (xferStart) firstBurst <= 1'b0;
    end
  end

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRelease && !oneShot) |=> !wordReq);

  p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (burstDone && oneShot && !lastBurst) |=> wordReq);

  p_disable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferEnd && !contMode && !runSet) |=> !chanActive);

  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive |-> !trigPend);

  p_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (xferEnd && contMode) |=> chanActive);
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int BURST_W = 5,
  parameter int XFER_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runSet,
  input  logic               trigIn,
  input  logic               oneShot,
  input  logic               contMode,
  input  logic               intAtEnd,
  input  logic               wide32,
  input  logic [BURST_W-1:0] burstSize,
  input  logic [XFER_W-1:0]  xferSize,
  input  logic               wordAck,
  output logic               wordReq,
  output logic               wordWide,
  output logic               wordDone,
  output logic               burstDone,
  output logic               xferStart,
  output logic               chanIrq,
  output logic               busRelease,
  output logic               chanActive
);
  seqCmd_t cmd;
  logic lastWord, lastBurst;

  assign wordWide = wide32;

  dma_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .runSet(runSet), .trigIn(trigIn),
    .oneShot(oneShot), .contMode(contMode), .intAtEnd(intAtEnd),
    .wordAck(wordAck), .lastWord(lastWord), .lastBurst(lastBurst),
    .cmd(cmd), .wordReq(wordReq), .wordDone(wordDone),
    .burstDone(burstDone), .xferStart(xferStart), .chanIrq(chanIrq),
    .busRelease(busRelease), .chanActive(chanActive)
  );

  dma_seq_count #(.BURST_W(BURST_W), .XFER_W(XFER_W)) count_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wide32(wide32),
    .burstSize(burstSize), .xferSize(xferSize),
    .lastWord(lastWord), .lastBurst(lastBurst)
  );
endmodule

// File: tb/dma_seq_top_tb_top.sv
module dma_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BURST_W = 5;
  localparam int XFER_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runSet = 1'b0, trigIn = 1'b0, oneShot = 1'b0, contMode = 1'b0;
  logic intAtEnd = 1'b0, wide32 = 1'b0, wordAck = 1'b0;
  logic [BURST_W-1:0] burstSize = '0;
  logic [XFER_W-1:0]  xferSize = '0;
  logic wordReq, wordWide, wordDone, burstDone, xferStart, chanIrq, busRelease, chanActive;

  int errors = 0, checks = 0, cycles = 0;
  int nWords = 0, nBursts = 0, nStarts = 0, nIrq = 0, nRel = 0, inBurst = 0;
  int expWords = 1;
  bit ackOn = 1'b1, monOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_seq_top #(.BURST_W(BURST_W), .XFER_W(XFER_W)) dut_i (
    .clk(clk), .rstN(rstN), .runSet(runSet), .trigIn(trigIn),
    .oneShot(oneShot), .contMode(contMode), .intAtEnd(intAtEnd),
    .wide32(wide32), .burstSize(burstSize), .xferSize(xferSize),
    .wordAck(wordAck), .wordReq(wordReq), .wordWide(wordWide),
    .wordDone(wordDone), .burstDone(burstDone), .xferStart(xferStart),
    .chanIrq(chanIrq), .busRelease(busRelease), .chanActive(chanActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wordsPerBurst(input int bs, input bit w);
    return w ? (bs + 2) / 2 : bs + 1;
  endfunction

  // acknowledge driver, away from the clock edge
  initial forever begin
    @(posedge clk);
    #1 wordAck = ackOn && ($urandom % 3 != 0);
  end

  // port monitor, sampled on the falling edge
  initial forever begin
    @(negedge clk);
    cycles++;
    if (monOn) begin
      if (wordReq) check(wordWide == wide32, "R3 wordWide", wordWide, wide32);
      if (wordDone) nWords++;
      if (xferStart) nStarts++;
      if (busRelease) nRel++;
      if (chanIrq) begin
        nIrq++;
        check(intAtEnd ? burstDone : xferStart, "R9 irq timing", 0, 1);
      end
      if (burstDone) begin
        nBursts++;
        check(inBurst + 1 == expWords, wide32 ? "R3 words/burst" : "R2 words/burst",
              inBurst + 1, expWords);
        inBurst = 0;
      end else if (wordDone) inBurst++;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic pulseRun();
    @(posedge clk); #1 runSet = 1'b1;
    @(posedge clk); #1 runSet = 1'b0;
  endtask

  task automatic pulseTrig();
    @(posedge clk); #1 trigIn = 1'b1;
    @(posedge clk); #1 trigIn = 1'b0;
  endtask

  task automatic waitBursts(input int n);
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      if (nBursts >= n) break;
    end
  endtask

  task automatic clearCounts();
    nWords = 0; nBursts = 0; nStarts = 0; nIrq = 0; nRel = 0; inBurst = 0;
  endtask

  task automatic runXfer(input int bs, input int xs, input bit w, input bit os,
                         input bit cm, input bit ie);
    @(posedge clk); #1;
    burstSize = BURST_W'(bs); xferSize = XFER_W'(xs); wide32 = w;
    oneShot = os; contMode = cm; intAtEnd = ie;
    expWords = wordsPerBurst(bs, w);
    clearCounts();
    pulseRun();
    if (os) begin
      pulseTrig();
      waitBursts(xs + 1);
    end else begin
      for (int b = 0; b <= xs; b++) begin
        pulseTrig();
        waitBursts(b + 1);
      end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(nBursts == xs + 1, "R4 bursts", nBursts, xs + 1);
    check(nWords == expWords * (xs + 1), "R4 total words", nWords, expWords * (xs + 1));
    check(nStarts == 1, "R4 xferStart", nStarts, 1);
    check(nIrq == 1, "R9 irq count", nIrq, 1);
    check(nRel == (os ? 1 : xs + 1), os ? "R6 release" : "R5 release", nRel, os ? 1 : xs + 1);
    check(chanActive == cm, cm ? "R8 stay active" : "R7 disable", chanActive, cm);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!chanActive && !wordReq && !busRelease && !chanIrq && !xferStart,
          "R1 reset outputs", {chanActive, wordReq, busRelease}, 0);
    #1 rstN = 1'b1;
    monOn = 1'b1;

    // R1/R7: trigger with the channel never enabled starts nothing
    pulseTrig();
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!wordReq && nBursts == 0, "R7 ignore when disabled", nBursts, 0);

    // directed corners: size extremes and width rounding
    runXfer(0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    runXfer(31, 1, 1'b0, 1'b1, 1'b0, 1'b1);
    runXfer(0, 2, 1'b1, 1'b0, 1'b0, 1'b1);
    runXfer(31, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    runXfer(4, 3, 1'b1, 1'b1, 1'b1, 1'b0);
    runXfer(5, 2, 1'b0, 1'b0, 1'b1, 1'b1);

    // R7: after a non-continuous transfer triggers are ignored
    runXfer(2, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    clearCounts();
    pulseTrig();
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(nBursts == 0 && !wordReq, "R7 trig after disable", nBursts, 0);

    // R10 / R5: several triggers during a burst collapse into one more burst
    @(posedge clk); #1;
    burstSize = 5'd3; xferSize = 16'd4; wide32 = 1'b0; oneShot = 1'b0;
    contMode = 1'b0; intAtEnd = 1'b0; expWords = 4;
    clearCounts();
    ackOn = 1'b0;
    pulseRun();
    pulseTrig();
    pulseTrig();
    pulseTrig();
    ackOn = 1'b1;
    repeat (200) @(posedge clk);
    @(negedge clk);
    check(nBursts == 2, "R10 pending collapse", nBursts, 2);
    check(nRel == 2, "R5 release per burst", nRel, 2);
    check(!wordReq, "R5 idle after release", wordReq, 0);
    for (int b = 2; b < 5; b++) begin
      pulseTrig();
      waitBursts(b + 1);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(nBursts == 5 && !chanActive, "R7 finish after pending", nBursts, 5);

    // constrained random transfers
    for (int t = 0; t < 30; t++) begin
      runXfer($urandom % 32, $urandom % 5, 1'($urandom % 2), 1'($urandom % 2),
              1'($urandom % 2), 1'($urandom % 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule